// File: doc/BRIEF.md
# Banked Data-Memory Access Decoder

This block resolves every data-memory access that a small 8-bit microcontroller core makes. The core presents a 7-bit direct address from the instruction word, a write strobe and write data each cycle. The block adds the bank-select bit held in its own status register to form the user-RAM address. Direct address 0 does not name a storage location: it means "use the pointer register", so the access goes through the pointer's low seven bits, still inside the bank chosen by the status bit.

The low part of each bank is a reserved window of special-function registers. These are kept in discrete flops outside the RAM and are reached from either bank at the same offsets. The registers are the pointer, status, program-counter low byte, program-counter high latch, interrupt control and output port. One location in the window reads the external input port. Locations at or above the window go to a two-bank single-port RAM.

Read data comes back one cycle after the address. The block also exposes the register values that the rest of the core needs, and the per-register write enables that its decoder raises. The controller drives one access per cycle with no handshake, so every pin is a plain control or data pin.

Top module: `banked_regfile`

## Requirements
- R1: After reset, acc_rdata, port_out, ptr_q, status_q, pcl_q, pclath_q and intcon_q are all 0x00.
- R2: A direct access with address at or above 0x0C reaches user RAM in the bank selected by status bit 5 (0 = bank 0, 1 = bank 1). The same offset in the two banks holds independent bytes.
- R3: acc_rdata presents, one cycle after the address, the value the location held before any write in that same cycle (read-first).
- R4: Direct address 0x00 accesses the location whose offset is the pointer's bits 6:0, in the bank given by status bit 5. Pointer bit 7 has no effect on the location.
- R5: An indirect access whose pointer offset is 0x00 reads 0x00, and when written it changes no register and no RAM byte and raises no write enable.
- R6: Special-function registers sit at the same offset in both banks: pointer 0x04, status 0x03, PC low 0x02, PC high latch 0x0A, interrupt control 0x0B, output port 0x06. Writing them never alters RAM.
- R7: Status keeps only bits 0, 1, 2 and 5, with bits 3, 4, 6 and 7 reading 0. Interrupt control keeps only bit 7. The PC high latch keeps only its low 5 bits, and the upper bits read 0.
- R8: port_out always equals the output-port register. A read of offset 0x05 returns port_in as sampled at the clock edge of the access.
- R9: The unimplemented reserved offsets 0x01, 0x07, 0x08 and 0x09 read 0x00 and ignore writes.
- R10: sfr_we (bit 0 pointer, 1 status, 2 PC low, 3 PC high latch, 4 interrupt control, 5 output port) is at most one-hot and is raised only while acc_wr is high for that register's offset. No register or RAM byte changes without acc_wr.
- R11: ptr_q, status_q, pcl_q, pclath_q and intcon_q show the current register values, with unimplemented bits at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 7 | Direct address from the instruction; 0x00 selects indirect |
| acc_wr | input | 1 | Write strobe for this cycle's access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, one cycle after the address |
| port_in | input | 8 | External input port, readable at offset 0x05 |
| port_out | output | 8 | Output-port register, driven straight to pins |
| sfr_we | output | 6 | Per-register write enables from the decoder |
| ptr_q | output | 8 | Pointer register |
| status_q | output | 8 | Status register (bank bit 5) |
| pcl_q | output | 8 | Program-counter low byte |
| pclath_q | output | 8 | Program-counter high latch |
| intcon_q | output | 8 | Interrupt control (bit 7 only) |

## Verification
The bench builds the block with its default parameters: a 7-bit bank offset, a 12-entry reserved window and a 5-bit high latch. Both 128-byte banks are fully written before the random phase, so every random read has a defined expected byte. Random pointer and status writes then move indirect accesses and bank switches across the whole space, including the pointer's unused bit 7 and the self-reference at offset zero. The masks of the high latch and the interrupt register are reached at their real widths.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DW       = 8;
  localparam int BANK_BIT = 5;
  localparam int NUM_SFR  = 6;
  localparam logic [DW-1:0] STATUS_KEEP = 8'h27;

  // Offsets inside the reserved window (fixed by the instruction encoding)
  localparam int OFS_INDIR = 0;
  localparam int OFS_PCL   = 2;
  localparam int OFS_STAT  = 3;
  localparam int OFS_PTR   = 4;
  localparam int OFS_PIN   = 5;
  localparam int OFS_POUT  = 6;
  localparam int OFS_PCH   = 10;
  localparam int OFS_INTC  = 11;

  typedef enum int {
    SFR_PTR  = 0,
    SFR_STAT = 1,
    SFR_PCL  = 2,
    SFR_PCH  = 3,
    SFR_INTC = 4,
    SFR_PORT = 5
  } sfr_idx_e;

  function automatic int sfr_offset(int idx);
    case (idx)
      SFR_PTR:  return OFS_PTR;
      SFR_STAT: return OFS_STAT;
      SFR_PCL:  return OFS_PCL;
      SFR_PCH:  return OFS_PCH;
      SFR_INTC: return OFS_INTC;
      SFR_PORT: return OFS_POUT;
      default:  return OFS_INDIR;
    endcase
  endfunction
endpackage

// File: rtl/rb_decode.sv
module rb_decode
  import regbank_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int SFR_SPAN = 12
) (
  input  logic [ADDR_W-1:0]  dir_addr,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  ptr_off,
  output logic [ADDR_W-1:0]  eff_off,
  output logic               in_window,
  output logic               self_ref,
  output logic               ram_we,
  output logic [NUM_SFR-1:0] sfr_we
);
  logic indirect;

  always_comb begin
    indirect  = (dir_addr == '0);
    eff_off   = indirect ? ptr_off : dir_addr;
    self_ref  = indirect && (ptr_off == '0);
    in_window = (eff_off < ADDR_W'(SFR_SPAN));
    ram_we    = wr && !in_window;
  end

  for (genvar i = 0; i < NUM_SFR; i++) begin : g_we
    assign sfr_we[i] = wr && !self_ref && (eff_off == ADDR_W'(sfr_offset(i)));
  end
endmodule

// File: rtl/rb_sfr.sv
module rb_sfr
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PCH_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SFR-1:0] we,
  input  logic [DW-1:0]      wdata,
  input  logic [ADDR_W-1:0]  rd_off,
  input  logic [DW-1:0]      port_in,
  output logic [DW-1:0]      ptr_q,
  output logic [DW-1:0]      status_q,
  output logic [DW-1:0]      pcl_q,
  output logic [DW-1:0]      pclath_q,
  output logic [DW-1:0]      intcon_q,
  output logic [DW-1:0]      port_q,
  output logic [DW-1:0]      rd_val
);
  localparam int PAD_W = DW - PCH_W;

  logic [DW-1:0]    ptr_r, stat_r, pcl_r, port_r;
  logic [PCH_W-1:0] pch_r;
  logic             ie_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_r  <= '0;
      stat_r <= '0;
      pcl_r  <= '0;
      pch_r  <= '0;
      ie_r   <= 1'b0;
      port_r <= '0;
    end else begin
      if (we[SFR_PTR])  ptr_r  <= wdata;
      if (we[SFR_STAT]) stat_r <= wdata & STATUS_KEEP;
      if (we[SFR_PCL])  pcl_r  <= wdata;
      if (we[SFR_PCH])  pch_r  <= wdata[PCH_W-1:0];
      if (we[SFR_INTC]) ie_r   <= wdata[DW-1];
      if (we[SFR_PORT]) port_r <= wdata;
    end
  end

  assign ptr_q    = ptr_r;
  assign status_q = stat_r;
  assign pcl_q    = pcl_r;
  assign pclath_q = {{PAD_W{1'b0}}, pch_r};
  assign intcon_q = {ie_r, {(DW-1){1'b0}}};
  assign port_q   = port_r;

  always_comb begin
    case (int'(rd_off))
      OFS_PTR:  rd_val = ptr_q;
      OFS_STAT: rd_val = status_q;
      OFS_PCL:  rd_val = pcl_q;
      OFS_PCH:  rd_val = pclath_q;
      OFS_INTC: rd_val = intcon_q;
      OFS_POUT: rd_val = port_q;
      OFS_PIN:  rd_val = port_in;
      default:  rd_val = '0;
    endcase
  end
endmodule

// File: rtl/rb_ram.sv
module rb_ram
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              bank,
  input  logic [ADDR_W-1:0] off,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int WORDS = 2 ** (ADDR_W + 1);

  logic [DW-1:0]     mem [WORDS];
  logic [ADDR_W:0]   idx;

  assign idx = {bank, off};

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[idx];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int SFR_SPAN = 12,
  parameter int PCH_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_wr,
  input  logic [DW-1:0]      acc_wdata,
  output logic [DW-1:0]      acc_rdata,
  input  logic [DW-1:0]      port_in,
  output logic [DW-1:0]      port_out,
  output logic [NUM_SFR-1:0] sfr_we,
  output logic [DW-1:0]      ptr_q,
  output logic [DW-1:0]      status_q,
  output logic [DW-1:0]      pcl_q,
  output logic [DW-1:0]      pclath_q,
  output logic [DW-1:0]      intcon_q
);
  logic [ADDR_W-1:0] eff_off;
  logic              in_window, self_ref, ram_we;
  logic [DW-1:0]     sfr_val, ram_q, sfr_rd_q;
  logic              from_ram_q;

  rb_decode #(.ADDR_W(ADDR_W), .SFR_SPAN(SFR_SPAN)) u_dec (
    .dir_addr  (acc_addr),
    .wr        (acc_wr),
    .ptr_off   (ptr_q[ADDR_W-1:0]),
    .eff_off   (eff_off),
    .in_window (in_window),
    .self_ref  (self_ref),
    .ram_we    (ram_we),
    .sfr_we    (sfr_we)
  );

  rb_sfr #(.ADDR_W(ADDR_W), .PCH_W(PCH_W)) u_sfr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (sfr_we),
    .wdata    (acc_wdata),
    .rd_off   (eff_off),
    .port_in  (port_in),
    .ptr_q    (ptr_q),
    .status_q (status_q),
    .pcl_q    (pcl_q),
    .pclath_q (pclath_q),
    .intcon_q (intcon_q),
    .port_q   (port_out),
    .rd_val   (sfr_val)
  );

  rb_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .bank  (status_q[BANK_BIT]),
    .off   (eff_off),
    .wdata (acc_wdata),
    .rdata (ram_q)
  );

  // Window reads are captured alongside the synchronous RAM read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sfr_rd_q   <= '0;
      from_ram_q <= 1'b0;
    end else begin
      sfr_rd_q   <= self_ref ? '0 : sfr_val;
      from_ram_q <= !in_window;
    end
  end

  assign acc_rdata = from_ram_q ? ram_q : sfr_rd_q;
endmodule

// File: rtl/rb_checker.sv
module rb_checker
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic               acc_wr,
  input logic [DW-1:0]      acc_rdata,
  input logic [DW-1:0]      port_out,
  input logic [NUM_SFR-1:0] sfr_we,
  input logic [DW-1:0]      ptr_q,
  input logic [DW-1:0]      status_q,
  input logic [DW-1:0]      intcon_q
);
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sfr_we)); // R10
  AST_WE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we != '0) |-> acc_wr); // R10
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_we[SFR_PTR] |=> $stable(ptr_q)); // R10
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_we[SFR_PORT] |=> $stable(port_out)); // R8
  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~STATUS_KEEP) == '0); // R7
  AST_INTC_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    intcon_q[DW-2:0] == '0); // R7
  AST_SELF_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == '0 && ptr_q[ADDR_W-1:0] == '0) |-> sfr_we == '0); // R5
  AST_SELF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == '0 && ptr_q[ADDR_W-1:0] == '0) |=> acc_rdata == '0); // R5
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == ADDR_W'(1) || (acc_addr >= ADDR_W'(7) && acc_addr <= ADDR_W'(9)))
    |=> acc_rdata == '0); // R9
endmodule

bind banked_regfile rb_checker #(.ADDR_W(ADDR_W)) u_rb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_addr  (acc_addr),
  .acc_wr    (acc_wr),
  .acc_rdata (acc_rdata),
  .port_out  (port_out),
  .sfr_we    (sfr_we),
  .ptr_q     (ptr_q),
  .status_q  (status_q),
  .intcon_q  (intcon_q)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] acc_addr = '0;
  logic       acc_wr = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic [7:0] port_in = '0;
  logic [7:0] port_out;
  logic [5:0] sfr_we;
  logic [7:0] ptr_q, status_q, pcl_q, pclath_q, intcon_q;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench model
  logic [7:0] m_ram [256];
  logic [7:0] m_ptr = '0, m_stat = '0, m_pcl = '0, m_pch = '0, m_intc = '0, m_port = '0;
  logic [7:0] exp_rd;
  bit         pending = 0;
  string      pend_tag;

  always #10 clk = ~clk; // 50 MHz

  banked_regfile uut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .port_in(port_in),
    .port_out(port_out), .sfr_we(sfr_we), .ptr_q(ptr_q), .status_q(status_q),
    .pcl_q(pcl_q), .pclath_q(pclath_q), .intcon_q(intcon_q)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff_off(logic [6:0] a);
    return (a == 0) ? int'(m_ptr[6:0]) : int'(a);
  endfunction

  function automatic logic [7:0] model_read(logic [6:0] a, logic [7:0] pin);
    int o = eff_off(a);
    case (o)
      2: return m_pcl;
      3: return m_stat;
      4: return m_ptr;
      5: return pin;
      6: return m_port;
      10: return m_pch;
      11: return m_intc;
      default: return (o < 12) ? 8'h00 : m_ram[{m_stat[5], o[6:0]}];
    endcase
  endfunction

  function automatic logic [5:0] model_we(logic [6:0] a, logic w);
    int o = eff_off(a);
    logic [5:0] v = '0;
    if (!w) return v;
    case (o)
      4: v[0] = 1'b1;
      3: v[1] = 1'b1;
      2: v[2] = 1'b1;
      10: v[3] = 1'b1;
      11: v[4] = 1'b1;
      6: v[5] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_write(logic [6:0] a, logic [7:0] d);
    int o = eff_off(a);
    logic b = m_stat[5];
    case (o)
      2: m_pcl = d;
      3: m_stat = d & 8'h27;
      4: m_ptr = d;
      6: m_port = d;
      10: m_pch = d & 8'h1F;
      11: m_intc = d & 8'h80;
      default: if (o >= 12) m_ram[{b, o[6:0]}] = d;
    endcase
  endtask

  // One access; compares read data and exposed registers at the falling edge
  task automatic op(logic [6:0] a, logic w, logic [7:0] d, logic [7:0] pin, string tag);
    @(negedge clk);
    if (pending) check({pend_tag, " rdata"}, acc_rdata, exp_rd);
    check("R8 port_out", port_out, m_port);
    check("R11 ptr_q", ptr_q, m_ptr);
    check("R11 status_q R7", status_q, m_stat);
    check("R11 pclath_q R7", pclath_q, m_pch);
    check("R11 intcon_q R7", intcon_q, m_intc);
    check("R11 pcl_q", pcl_q, m_pcl);
    acc_addr = a; acc_wr = w; acc_wdata = d; port_in = pin;
    #1;
    check({tag, " R10 sfr_we"}, {2'b00, sfr_we}, {2'b00, model_we(a, w)});
    exp_rd = model_read(a, pin);
    if (w) model_write(a, d);
    pending = 1;
    pend_tag = tag;
  endtask

  task automatic flush();
    op(7'h01, 1'b0, 8'h00, 8'h00, "R9 idle");
    @(negedge clk);
    check({pend_tag, " rdata"}, acc_rdata, exp_rd);
    pending = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] seed_init;
    seed_init = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check("R1 rdata", acc_rdata, 8'h00);
    check("R1 port_out", port_out, 8'h00);
    check("R1 status_q", status_q, 8'h00);
    check("R1 ptr_q", ptr_q, 8'h00);
    check("R1 pclath_q", pclath_q, 8'h00);
    check("R1 intcon_q", intcon_q, 8'h00);
    rst_n = 1'b1;

    // Fill both banks
    for (int b = 0; b < 2; b++) begin
      op(7'h03, 1'b1, b ? 8'h20 : 8'h00, 8'h00, "R6 bank sel");
      for (int o = 12; o < 128; o++)
        op(7'(o), 1'b1, 8'($urandom), 8'h00, "R2 fill");
    end

    // R2: same offset, distinct banks
    op(7'h03, 1'b1, 8'h00, 8'h00, "R2 bank0");
    op(7'h20, 1'b1, 8'hA5, 8'h00, "R2 wr b0");
    op(7'h03, 1'b1, 8'h20, 8'h00, "R2 bank1");
    op(7'h20, 1'b1, 8'h5A, 8'h00, "R2 wr b1");
    op(7'h20, 1'b0, 8'h00, 8'h00, "R2 rd b1");
    op(7'h03, 1'b1, 8'h00, 8'h00, "R2 bank0 again");
    op(7'h20, 1'b0, 8'h00, 8'h00, "R2 rd b0");
    // R3: read-first on write
    op(7'h30, 1'b1, 8'h11, 8'h00, "R3 rw same cycle");
    op(7'h30, 1'b0, 8'h00, 8'h00, "R3 read new");
    // R4: indirect, pointer bit 7 ignored
    op(7'h04, 1'b1, 8'hB0, 8'h00, "R4 ptr set");
    op(7'h00, 1'b1, 8'h77, 8'h00, "R4 ind wr");
    op(7'h30, 1'b0, 8'h00, 8'h00, "R4 direct view");
    op(7'h03, 1'b1, 8'h20, 8'h00, "R4 bank1");
    op(7'h00, 1'b0, 8'h00, 8'h00, "R4 ind rd b1");
    op(7'h04, 1'b1, 8'h86, 8'h00, "R4 ptr to port");
    op(7'h00, 1'b1, 8'hC3, 8'h00, "R4 ind wr port");
    // R5: self reference
    op(7'h04, 1'b1, 8'h80, 8'h00, "R5 ptr self");
    op(7'h00, 1'b1, 8'hFF, 8'h00, "R5 self wr");
    op(7'h00, 1'b0, 8'h00, 8'h00, "R5 self rd");
    // R6: mirror from bank1 reads back in bank0
    op(7'h0A, 1'b1, 8'hFF, 8'h00, "R6 R7 pch wr");
    op(7'h0B, 1'b1, 8'hFF, 8'h00, "R7 intc wr");
    op(7'h03, 1'b1, 8'hFF, 8'h00, "R7 status wr");
    op(7'h0A, 1'b0, 8'h00, 8'h00, "R6 pch rd b1");
    op(7'h03, 1'b1, 8'h00, 8'h00, "R6 bank0");
    op(7'h0A, 1'b0, 8'h00, 8'h00, "R6 pch rd b0");
    op(7'h06, 1'b0, 8'h00, 8'h00, "R6 port rd b0");
    // R8: input port sampled
    op(7'h05, 1'b1, 8'h12, 8'h9C, "R8 pin rd");
    // R9: unimplemented
    op(7'h01, 1'b1, 8'hEE, 8'h00, "R9 wr 01");
    op(7'h08, 1'b1, 8'hEE, 8'h00, "R9 wr 08");
    op(7'h08, 1'b0, 8'h00, 8'h00, "R9 rd 08");
    // R10: no strobe, no change
    op(7'h06, 1'b0, 8'h00, 8'h00, "R10 port no strobe");
    op(7'h40, 1'b0, 8'hDD, 8'h00, "R10 ram no strobe");
    op(7'h40, 1'b0, 8'h00, 8'h00, "R10 ram unchanged");

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] a;
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom_range(0, 1)) a = 7'($urandom_range(0, 15));
      else a = 7'($urandom);
      if (a == 7'h03) d = d & 8'hFB;
      op(a, 1'($urandom_range(0, 1)), d, 8'($urandom), "R2 R3 R4 R6 random");
    end
    flush();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule